// File: doc/BRIEF.md
# Center-Aligned PWM Timer with Buffered Period and Threshold

This block is a 16-bit up/down timer with a single compare channel that produces a center-aligned pulse-width-modulated output. On each count tick the counter climbs from zero to a programmable ceiling (TOP), then descends back to zero, and repeats. The pulse is centered on the zero point of each cycle. The pulse width is set by a compare threshold.

Software never writes the live ceiling or threshold directly. It loads two shadow registers through a shared write-data bus. A commit-point select decides whether the shadows are copied into the live registers when the counter turns at zero or when it turns at the ceiling. Committing at zero keeps every period symmetric and frequency-exact. Committing at the ceiling lets a new ceiling act halfway through a cycle.

The ceiling comes either from the period shadow or from the threshold itself. A rate select picks a tick rate of 1, 8, 64, 256 or 1024 input clocks per count. The output stage can be held low, can toggle on matches, or can drive the pulse non-inverted or inverted.

Top module: `updown_pwm`

## Requirements
- R1: Out of reset the counter reads 0 with the direction flag set to descending (`count_down_o` = 1). On each tick it advances by one along the sequence 0, 1, …, TOP, TOP-1, …, 1, 0, 1, …. Each endpoint is held for exactly one tick per cycle.
- R2: `rate_sel` encodes the ticks: 1 = every clock, 2 = every 8, 3 = every 64, 4 = every 256, 5 = every 1024. The values 0, 6 and 7 stop counting, and the count holds. One full cycle lasts 2·TOP·N clocks, where N is the division.
- R3: With `top_from_cmp` = 0, TOP is the live period value. With `top_from_cmp` = 1, TOP is the live threshold. Any TOP below 3 acts as 3.
- R4: With `out_mode` = 2'b10 (non-inverting), the output falls at the tick that processes count = C while ascending. It rises at the tick that processes count = C while descending. It is therefore high for 2·C·N clocks of every cycle.
- R5: In non-inverting mode, a threshold of 0 gives a constant low output. A threshold at or above TOP gives a constant high output.
- R6: With `out_mode` = 2'b11 (inverting), the output is the complement of the non-inverting waveform, including the cases of R5.
- R7: With `out_mode` = 2'b01 (toggle), the output flips at every tick that processes count = C. When the threshold defines TOP, this gives a 50% square wave with twice the cycle length.
- R8: With `out_mode` = 2'b00, the output is held low.
- R9: With `commit_at_bottom` = 1, the shadows are copied to the live registers only at the tick that processes count 0. A write during a cycle leaves that cycle's ceiling and pulse unchanged.
- R10: With `commit_at_bottom` = 0, the shadows are copied at the tick that processes the ceiling. The descending slope keeps the old TOP and the next ascending slope uses the new one.
- R11: Reset loads TOP = 3 and threshold = 0 into both the shadow and the live registers, and drives the output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 3 | Tick rate select (R2 encoding) |
| commit_at_bottom | input | 1 | 1 = commit shadows at zero, 0 = at ceiling |
| top_from_cmp | input | 1 | 1 = threshold defines TOP |
| out_mode | input | 2 | 00 off, 01 toggle, 10 non-inverting, 11 inverting |
| period_wr | input | 1 | Load `wr_data` into the period shadow |
| cmp_wr | input | 1 | Load `wr_data` into the threshold shadow |
| wr_data | input | 16 | Shadow write data |
| pwm_out | output | 1 | Waveform output |
| count_o | output | 16 | Current count |
| count_down_o | output | 1 | 1 while the count is descending |

## Verification
The bench keeps the default 16-bit count. It programs ceilings of only 3 to 10, so every threshold from 0 through TOP+1 can be swept at full rate within a few hundred clocks. High time per cycle and cycle length are compared against 2·C·N and 2·TOP·N. Short ceilings also make the slowest rate divisions of 256 and 1024 affordable, together with mid-cycle shadow writes under both commit points, where the observed peak count shows which ceiling each slope used.

// File: rtl/updown_pwm_pkg.sv
package updown_pwm_pkg;

    localparam int CNT_W   = 16;
    localparam int PRE_W   = 10;
    localparam int MIN_TOP = 3;

    typedef enum logic [1:0] {
        OUT_OFF    = 2'b00,
        OUT_TOGGLE = 2'b01,
        OUT_NONINV = 2'b10,
        OUT_INV    = 2'b11
    } out_mode_e;

    typedef struct packed {
        logic [CNT_W-1:0] top;
        logic [CNT_W-1:0] cmp;
    } pwm_regs_t;

    localparam pwm_regs_t REGS_RESET = '{top: CNT_W'(MIN_TOP), cmp: '0};

    function automatic logic rate_on(input logic [2:0] sel);
        return (sel >= 3'd1) && (sel <= 3'd5);
    endfunction

    // last prescale count before a tick (division minus one)
    function automatic logic [PRE_W-1:0] rate_last(input logic [2:0] sel);
        case (sel)
            3'd2:    return PRE_W'(7);
            3'd3:    return PRE_W'(63);
            3'd4:    return PRE_W'(255);
            3'd5:    return PRE_W'(1023);
            default: return '0;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] clamp_top(input logic [CNT_W-1:0] t);
        return (t < CNT_W'(MIN_TOP)) ? CNT_W'(MIN_TOP) : t;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import updown_pwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] rate_sel,
    output logic       tick
);

    logic [PRE_W-1:0] pre_q;
    logic             run;
    logic [PRE_W-1:0] last;

    assign run  = rate_on(rate_sel);
    assign last = rate_last(rate_sel);
    assign tick = run && (pre_q >= last);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    // R2: a stopped rate produces no tick
    p_stop_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
        (rate_sel == 3'd0 || rate_sel > 3'd5) |-> !tick);

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import updown_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             commit_at_bottom,
    input  logic             top_from_cmp,
    input  logic             period_wr,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt,
    output logic             down,
    output logic [CNT_W-1:0] live_cmp,
    output logic [CNT_W-1:0] eff_top
);

    pwm_regs_t shadow_q;
    pwm_regs_t live_q;
    logic      at_bottom;
    logic      at_top;
    logic      commit;

    assign eff_top   = clamp_top(top_from_cmp ? live_q.cmp : live_q.top);
    assign live_cmp  = live_q.cmp;
    assign at_bottom = down && (cnt == '0);
    assign at_top    = !down && (cnt >= eff_top);
    assign commit    = tick && (commit_at_bottom ? at_bottom : at_top);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            down     <= 1'b1;
            shadow_q <= REGS_RESET;
            live_q   <= REGS_RESET;
        end else begin
            if (period_wr) shadow_q.top <= wr_data;
            if (cmp_wr)    shadow_q.cmp <= wr_data;
            if (commit)    live_q       <= shadow_q;
            if (tick) begin
                if (at_bottom) begin
                    cnt  <= CNT_W'(1);
                    down <= 1'b0;
                end else if (at_top) begin
                    cnt  <= cnt - CNT_W'(1);
                    down <= 1'b1;
                end else if (down) begin
                    cnt  <= cnt - CNT_W'(1);
                end else begin
                    cnt  <= cnt + CNT_W'(1);
                end
            end
        end
    end

    // R1: every tick moves the count by exactly one
    p_unit_step_r1: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == $past(cnt) + CNT_W'(1)) || (cnt == $past(cnt) - CNT_W'(1)));

    // R2: without a tick the counter holds
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt) && $stable(down));

    // R9: in bottom-commit mode live values change only after processing zero
    p_bottom_commit_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(commit_at_bottom) && !$stable(live_q)) |->
            ($past(cnt) == '0) && $past(down) && $past(tick));

    // R10: in ceiling-commit mode live values change only after the turn at TOP
    p_top_commit_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(commit_at_bottom) && !$stable(live_q)) |->
            !$past(down) && ($past(cnt) >= $past(eff_top)) && $past(tick));

endmodule

// File: rtl/pwm_wavegen.sv
module pwm_wavegen
    import updown_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic             down,
    input  logic [CNT_W-1:0] cmp,
    input  logic [CNT_W-1:0] top,
    input  logic [1:0]       out_mode,
    output logic             pwm_out
);

    logic lvl_q;
    logic lvl_d;
    logic tog_q;

    always_comb begin
        if (cmp == '0)       lvl_d = 1'b0;
        else if (cmp >= top) lvl_d = 1'b1;
        else if (down)       lvl_d = (cnt <= cmp);
        else                 lvl_d = (cnt < cmp);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b0;
            tog_q <= 1'b0;
        end else if (tick) begin
            lvl_q <= lvl_d;
            tog_q <= tog_q ^ (cnt == cmp);
        end
    end

    always_comb begin
        case (out_mode_e'(out_mode))
            OUT_TOGGLE: pwm_out = tog_q;
            OUT_NONINV: pwm_out = lvl_q;
            OUT_INV:    pwm_out = ~lvl_q;
            default:    pwm_out = 1'b0;
        endcase
    end

    // R5: a zero threshold keeps the pulse low
    p_floor_low_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && cmp == '0) |=> !lvl_q);

    // R5: a threshold at or above TOP keeps the pulse high
    p_ceiling_high_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && cmp != '0 && cmp >= top) |=> lvl_q);

    // R7: a match flips the toggle output
    p_match_flip_r7: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt == cmp) |=> (tog_q != $past(tog_q)));

endmodule

// File: rtl/updown_pwm.sv
module updown_pwm
    import updown_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       rate_sel,
    input  logic             commit_at_bottom,
    input  logic             top_from_cmp,
    input  logic [1:0]       out_mode,
    input  logic             period_wr,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_out,
    output logic [CNT_W-1:0] count_o,
    output logic             count_down_o
);

    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             down;
    logic [CNT_W-1:0] live_cmp;
    logic [CNT_W-1:0] eff_top;

    pwm_prescaler u_pre (
        .clk      (clk),
        .rst      (rst),
        .rate_sel (rate_sel),
        .tick     (tick)
    );

    pwm_counter u_cnt (
        .clk              (clk),
        .rst              (rst),
        .tick             (tick),
        .commit_at_bottom (commit_at_bottom),
        .top_from_cmp     (top_from_cmp),
        .period_wr        (period_wr),
        .cmp_wr           (cmp_wr),
        .wr_data          (wr_data),
        .cnt              (cnt),
        .down             (down),
        .live_cmp         (live_cmp),
        .eff_top          (eff_top)
    );

    pwm_wavegen u_wave (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .cnt      (cnt),
        .down     (down),
        .cmp      (live_cmp),
        .top      (eff_top),
        .out_mode (out_mode),
        .pwm_out  (pwm_out)
    );

    assign count_o      = cnt;
    assign count_down_o = down;

    // R8: the disconnected mode drives low at the pin
    p_off_low_r8: assert property (@(posedge clk) disable iff (rst)
        (out_mode == 2'b00) |-> !pwm_out);

    // R3: the count never exceeds the larger of the live ceiling choices
    p_count_bounded_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !down && cnt < eff_top) |=> (cnt <= eff_top));

endmodule

// File: tb/updown_pwm_tb.sv
module updown_pwm_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  rate_sel;
    logic        commit_at_bottom;
    logic        top_from_cmp;
    logic [1:0]  out_mode;
    logic        period_wr;
    logic        cmp_wr;
    logic [15:0] wr_data;
    logic        pwm_out;
    logic [15:0] count_o;
    logic        count_down_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    updown_pwm u_dut (
        .clk              (clk),
        .rst              (rst),
        .rate_sel         (rate_sel),
        .commit_at_bottom (commit_at_bottom),
        .top_from_cmp     (top_from_cmp),
        .out_mode         (out_mode),
        .period_wr        (period_wr),
        .cmp_wr           (cmp_wr),
        .wr_data          (wr_data),
        .pwm_out          (pwm_out),
        .count_o          (count_o),
        .count_down_o     (count_down_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit at_bot();
        return (count_o == 16'd0) && count_down_o;
    endfunction

    task automatic measure(output int cyc, output int peak);
        bit prev;
        prev = at_bot();
        cyc  = 0;
        peak = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (int'(count_o) > peak) peak = int'(count_o);
            if (at_bot() && !prev) break;
            prev = at_bot();
        end
    endtask

    task automatic high_time(input int win, output int hi);
        hi = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
    endtask

    task automatic wr_top(input int v);
        period_wr = 1'b1;
        wr_data   = 16'(v);
        @(negedge clk);
        period_wr = 1'b0;
    endtask

    task automatic wr_cmp(input int v);
        cmp_wr  = 1'b1;
        wr_data = 16'(v);
        @(negedge clk);
        cmp_wr  = 1'b0;
    endtask

    task automatic wait_count(input int v, input bit dn);
        do @(negedge clk); while (!(int'(count_o) == v && count_down_o == dn));
    endtask

    function automatic int noninv_high(input int t, input int c, input int n);
        if (c == 0) return 0;
        if (c >= t) return 2 * t * n;
        return 2 * c * n;
    endfunction

    // program shadows, let them commit, then check cycle length and high time
    task automatic run_case(input string tag, input int top, input int cmp,
                            input int teff, input logic [2:0] sel, input int n,
                            input logic [1:0] mode, input int win, input int exp_hi);
        int cyc;
        int pk;
        int hi;
        rate_sel = sel;
        out_mode = mode;
        wr_top(top);
        wr_cmp(cmp);
        measure(cyc, pk);
        measure(cyc, pk);
        measure(cyc, pk);
        chk({tag, " period R1 R2"}, cyc, 2 * teff * n);
        chk({tag, " peak R1"}, pk, teff);
        high_time(win, hi);
        chk({tag, " high"}, hi, exp_hi);
    endtask

    initial begin
        int wd = 0;
        while (!done) begin
            @(posedge clk);
            wd++;
            if (wd > 190000 && !done) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: got %0d expected below %0d cycles", wd, 190000);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        int cyc;
        int pk;
        int hi;
        int held;
        rst = 1'b1;
        rate_sel = 3'd0;
        commit_at_bottom = 1'b1;
        top_from_cmp = 1'b0;
        out_mode = 2'b10;
        period_wr = 1'b0;
        cmp_wr = 1'b0;
        wr_data = '0;
        repeat (3) @(negedge clk);
        // R11 / R1: reset state
        chk("R11 reset count", int'(count_o), 0);
        chk("R1 reset dir", int'(count_down_o), 1);
        chk("R11 reset out", int'(pwm_out), 0);
        rst = 1'b0;

        // R11: defaults give TOP 3 and threshold 0
        rate_sel = 3'd1;
        measure(cyc, pk);
        measure(cyc, pk);
        chk("R11 default period", cyc, 6);
        high_time(6, hi);
        chk("R11 default high", hi, 0);

        // R4 R5: non-inverting sweep at full rate
        for (int t = 3; t <= 10; t += 3) begin
            for (int c = 0; c <= t + 1; c++) begin
                run_case("R4 R5 noninv", t, c, t, 3'd1, 1, 2'b10, 2 * t,
                         noninv_high(t, c, 1));
            end
        end

        // R6: inverting sweep
        for (int c = 0; c <= 7; c++) begin
            run_case("R6 inv", 6, c, 6, 3'd1, 1, 2'b11, 12, 12 - noninv_high(6, c, 1));
        end

        // R8: off mode
        run_case("R8 off", 6, 3, 6, 3'd1, 1, 2'b00, 12, 0);

        // R3: TOP below minimum acts as 3
        run_case("R3 clamp", 1, 1, 3, 3'd1, 1, 2'b10, 6, 2);

        // R3 R5: threshold defines TOP, pulse saturates high
        top_from_cmp = 1'b1;
        run_case("R3 R5 cmp-top", 9, 5, 5, 3'd1, 1, 2'b10, 10, 10);
        // R7: toggle gives 50% square over two cycles
        run_case("R7 toggle", 9, 5, 5, 3'd1, 1, 2'b01, 20, 10);
        top_from_cmp = 1'b0;

        // R2: slower divisions
        for (int c = 0; c <= 4; c++) begin
            run_case("R2 div8", 4, c, 4, 3'd2, 8, 2'b10, 64, noninv_high(4, c, 8));
        end
        run_case("R2 div64", 3, 1, 3, 3'd3, 64, 2'b10, 384, 128);
        run_case("R2 div256", 3, 2, 3, 3'd4, 256, 2'b11, 1536, 1536 - 1024);
        run_case("R2 div1024", 3, 1, 3, 3'd5, 1024, 2'b10, 6144, 2048);

        // R2: stopped rates hold the count
        run_case("R2 pre-stop", 6, 2, 6, 3'd1, 1, 2'b10, 12, 4);
        rate_sel = 3'd0;
        @(negedge clk);
        held = int'(count_o);
        repeat (20) @(negedge clk);
        chk("R2 stop code 0", int'(count_o), held);
        rate_sel = 3'd6;
        repeat (20) @(negedge clk);
        chk("R2 stop code 6", int'(count_o), held);

        // R9: mid-cycle writes do not disturb the cycle in progress
        commit_at_bottom = 1'b1;
        run_case("R9 setup", 6, 2, 6, 3'd1, 1, 2'b10, 12, 4);
        wait_count(3, 1'b0);
        wr_top(10);
        wr_cmp(5);
        measure(cyc, pk);
        chk("R9 current peak", pk, 6);
        measure(cyc, pk);
        chk("R9 next period", cyc, 20);
        chk("R9 next peak", pk, 10);
        high_time(20, hi);
        chk("R9 next high", hi, 10);

        // R10: ceiling commit, write during descent
        commit_at_bottom = 1'b0;
        run_case("R10 setup", 4, 2, 4, 3'd1, 1, 2'b10, 8, 4);
        wait_count(2, 1'b1);
        wr_top(8);
        measure(cyc, pk);
        measure(cyc, pk);
        chk("R10 old rise period", cyc, 8);
        chk("R10 old rise peak", pk, 4);
        measure(cyc, pk);
        chk("R10 new period", cyc, 16);
        chk("R10 new peak", pk, 8);
        // R10: write during ascent, descent keeps the old ceiling
        wait_count(2, 1'b0);
        wr_top(4);
        measure(cyc, pk);
        chk("R10 old fall peak", pk, 8);
        measure(cyc, pk);
        chk("R10 shrunk period", cyc, 8);
        chk("R10 shrunk peak", pk, 4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule